// File: doc/BRIEF.md
# Prescaled Event Spy Tap

The tap sits on a word stream that carries whole events: each word arrives with a valid/ready handshake, and a marker flags the last word of an event. Every word passes through to the downstream consumer without delay and without change. The tap can also copy chosen events, complete, into a monitoring path. That path has two write ports. One carries the copied data words. The other carries one length entry per copied event, which gives the number of words in that event.

A two-bit selection field turns copying off, copies every event, or copies one event in n. The value n is programmed as n−1 in a 16-bit field, so n runs from 1 to 65536. Both monitoring FIFOs report an almost-full flag. In the default mode the tap never slows the stream. An event that cannot be copied because a monitoring FIFO is nearly full is left out, and a saturating counter records it. In the optional blocking mode the tap instead holds the first word of a selected event until both flags clear.

A small state machine controls the tap. In `ST_IDLE` it waits at an event boundary. The first word of an event is accepted there and takes the machine to `ST_COPY` (event selected and room in the FIFOs) or to `ST_PASS` (event not selected, or dropped for lack of room). Acceptance of the last word returns the machine to `ST_IDLE` from any state. A one-word event never leaves `ST_IDLE`. In blocking mode, a selected event meeting a nearly-full FIFO makes `ST_IDLE` withhold ready until the FIFOs have room.

Top module: `spy_tap`

## Requirements
- R1: While reset is held, and right after it, both monitoring write strobes are low and the skip counter reads 0.
- R2: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, except during a blocking-mode stall. `out_data` and `out_last` always equal `in_data` and `in_last`. In non-blocking mode there is never a stall.
- R3: `cfg_mode` encoding: 0 copies nothing, 1 copies every event, 2 copies one event in n, and 3 behaves like 0.
- R4: In mode 2 the tap counts the events accepted since reset, starting at index 0, and selects an event when its index is a multiple of n = `cfg_div_m1`+1. `cfg_div_m1`=0 selects every event. 0xFFFF selects only every 65536th event.
- R5: The copy decision is taken when the first word of an event is accepted, and it holds for the whole event. Almost-full flags that change inside an event neither start nor cut a copy.
- R6: In non-blocking mode, a selected event whose first word is accepted while either almost-full flag is high is not copied at all, and the skip counter increments by one.
- R7: In blocking mode (`cfg_block`=1), the first word of a selected event is not accepted (`in_ready`=0, `out_valid`=0) while either flag is high. Once both flags are low it is accepted and the event is copied. The skip counter does not move.
- R8: For every accepted word of a copied event, `spy_dat_we` is high in the next cycle and `spy_dat` carries that word. The strobe is low at all other times.
- R9: In the cycle after the last word of a copied event is accepted, `spy_len_we` is high and `spy_len` gives the event's word count, counting both the first and the last word.
- R10: The skip counter saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Selection field (R3) |
| cfg_div_m1 | input | DIV_W | n−1 for one-in-n selection |
| cfg_block | input | 1 | 1: stall instead of dropping |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream word accepted |
| in_data | input | DATA_W | Upstream word |
| in_last | input | 1 | Word is last of its event |
| out_valid | output | 1 | Downstream word valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | DATA_W | Downstream word |
| out_last | output | 1 | Downstream last-word flag |
| spy_dat_we | output | 1 | Monitoring data write strobe |
| spy_dat | output | DATA_W | Monitoring data word |
| spy_dat_af | input | 1 | Monitoring data FIFO almost full |
| spy_len_we | output | 1 | Monitoring length write strobe |
| spy_len | output | LEN_W | Word count of the copied event |
| spy_len_af | input | 1 | Monitoring length FIFO almost full |
| skip_count | output | SKIP_W | Events dropped for lack of room |

## Verification
The overlap that matters is a last word and a next first word landing in back-to-back cycles, while an almost-full flag switches on the very edge where the copy decision is taken. A length write, the prescale step and a skip or stall can then all fall together. Random almost-full flags change every cycle at high probability, and random gaps on both sides of the handshake often produce one-word events and first words that follow a last word directly. A cycle model in the bench makes each decision from the flags seen on the accepting edge and predicts the monitoring writes for the next cycle. It also checks ready and valid in every cycle, so a stall that comes one edge late or a copy cut in the middle is caught.

// File: rtl/spy_tap_pkg.sv
`timescale 1ns/1ps
package spy_tap_pkg;

    typedef enum logic [1:0] {
        SPY_OFF      = 2'd0,
        SPY_EVERY    = 2'd1,
        SPY_ONE_IN_N = 2'd2,
        SPY_RSVD     = 2'd3
    } spy_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COPY = 2'd1,
        ST_PASS = 2'd2
    } tap_state_e;

endpackage

// File: rtl/spy_prescaler.sv
`timescale 1ns/1ps
module spy_prescaler
    import spy_tap_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  spy_mode_e        mode,
    input  logic [DIV_W-1:0] div_m1,
    input  logic             evt_taken,
    output logic             want
);

    logic [DIV_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (evt_taken && mode == SPY_ONE_IN_N) begin
            if (phase_q >= div_m1) phase_q <= '0;
            else                   phase_q <= phase_q + 1'b1;
        end
    end

    always_comb begin
        unique case (mode)
            SPY_EVERY:    want = 1'b1;
            SPY_ONE_IN_N: want = (phase_q == '0);
            default:      want = 1'b0;
        endcase
    end

endmodule

// File: rtl/spy_ctrl.sv
`timescale 1ns/1ps
module spy_ctrl
    import spy_tap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_last,
    input  logic out_ready,
    input  logic want,
    input  logic room,
    input  logic blocking,
    output logic stall,
    output logic word_hs,
    output logic first_word,
    output logic copy_word,
    output logic drop_evt
);

    tap_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        stall      = 1'b0;
        first_word = 1'b0;
        copy_word  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                first_word = 1'b1;
                copy_word  = want && room;
                stall      = in_valid && want && !room && blocking;
            end
            ST_COPY: copy_word = 1'b1;
            ST_PASS: copy_word = 1'b0;
            default: copy_word = 1'b0;
        endcase
        word_hs  = in_valid && out_ready && !stall;
        drop_evt = first_word && word_hs && want && !room;
    end

    always_comb begin
        state_d = state_q;
        if (word_hs) begin
            if (in_last)        state_d = ST_IDLE;
            else if (copy_word) state_d = ST_COPY;
            else                state_d = ST_PASS;
        end
    end

endmodule

// File: rtl/spy_writer.sv
`timescale 1ns/1ps
module spy_writer #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_hs,
    input  logic              first_word,
    input  logic              copy_word,
    input  logic              last_word,
    input  logic [DATA_W-1:0] word,
    output logic              dat_we,
    output logic [DATA_W-1:0] dat,
    output logic              len_we,
    output logic [LEN_W-1:0]  len
);

    logic [LEN_W-1:0] count_q;
    logic [LEN_W-1:0] count_now;

    assign count_now = (first_word ? '0 : count_q) + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            dat_we  <= 1'b0;
            dat     <= '0;
            len_we  <= 1'b0;
            len     <= '0;
        end else begin
            dat_we <= word_hs && copy_word;
            len_we <= word_hs && copy_word && last_word;
            if (word_hs) begin
                count_q <= count_now;
                dat     <= word;
                len     <= count_now;
            end
        end
    end

endmodule

// File: rtl/spy_skip_ctr.sv
`timescale 1ns/1ps
module spy_skip_ctr #(
    parameter int SKIP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bump,
    output logic [SKIP_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= '0;
        else if (bump && count != '1) count <= count + 1'b1;
    end

endmodule

// File: rtl/spy_tap.sv
`timescale 1ns/1ps
module spy_tap
    import spy_tap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    parameter int DIV_W  = 16,
    parameter int SKIP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [DIV_W-1:0]  cfg_div_m1,
    input  logic              cfg_block,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              spy_dat_we,
    output logic [DATA_W-1:0] spy_dat,
    input  logic              spy_dat_af,
    output logic              spy_len_we,
    output logic [LEN_W-1:0]  spy_len,
    input  logic              spy_len_af,
    output logic [SKIP_W-1:0] skip_count
);

    spy_mode_e mode;
    logic want, room, stall, word_hs, first_word, copy_word, drop_evt;

    assign mode = spy_mode_e'(cfg_mode);
    assign room = !spy_dat_af && !spy_len_af;

    assign in_ready  = out_ready && !stall;
    assign out_valid = in_valid && !stall;
    assign out_data  = in_data;
    assign out_last  = in_last;

    spy_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .div_m1    (cfg_div_m1),
        .evt_taken (word_hs && first_word),
        .want      (want)
    );

    spy_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .out_ready  (out_ready),
        .want       (want),
        .room       (room),
        .blocking   (cfg_block),
        .stall      (stall),
        .word_hs    (word_hs),
        .first_word (first_word),
        .copy_word  (copy_word),
        .drop_evt   (drop_evt)
    );

    spy_writer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_hs    (word_hs),
        .first_word (first_word),
        .copy_word  (copy_word),
        .last_word  (in_last),
        .word       (in_data),
        .dat_we     (spy_dat_we),
        .dat        (spy_dat),
        .len_we     (spy_len_we),
        .len        (spy_len)
    );

    spy_skip_ctr #(.SKIP_W(SKIP_W)) u_skip (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (drop_evt),
        .count (skip_count)
    );

endmodule

// File: rtl/spy_tap_chk.sv
`timescale 1ns/1ps
module spy_tap_chk #(
    parameter int DATA_W = 32,
    parameter int SKIP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_block,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic              spy_dat_we,
    input logic [DATA_W-1:0] spy_dat,
    input logic              spy_len_we,
    input logic [SKIP_W-1:0] skip_count
);

    // R2
    pass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_block |-> (in_ready == out_ready));

    // R2
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);

    // R8
    copy_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spy_dat_we |-> ($past(in_valid && in_ready) && spy_dat == $past(in_data)));

    // R9
    len_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spy_len_we |-> spy_dat_we);

    // R10
    skip_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_count >= $past(skip_count));

endmodule

bind spy_tap spy_tap_chk #(.DATA_W(DATA_W), .SKIP_W(SKIP_W)) u_spy_tap_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_block  (cfg_block),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .spy_dat_we (spy_dat_we),
    .spy_dat    (spy_dat),
    .spy_len_we (spy_len_we),
    .skip_count (skip_count)
);

// File: tb/test_spy_tap.sv
`timescale 1ns/1ps
module test_spy_tap;

    localparam int DW = 32;
    localparam int LW = 16;
    localparam int VW = 16;
    localparam int SW = 4;
    localparam int SKIP_MAX = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [VW-1:0] cfg_div_m1 = '0;
    logic          cfg_block = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_last;
    logic          spy_dat_we;
    logic [DW-1:0] spy_dat;
    logic          spy_dat_af = 1'b0;
    logic          spy_len_we;
    logic [LW-1:0] spy_len;
    logic          spy_len_af = 1'b0;
    logic [SW-1:0] skip_count;

    int checks = 0;
    int errors = 0;

    // bench model state
    bit      m_in_evt;
    bit      m_copy;
    int      m_pc;
    int      m_wcnt;
    int      m_skip;
    bit      e_dwe;
    bit      e_lwe;
    longint  e_dat;
    longint  e_len;
    // stimulus state
    bit      pend;
    int      rem;

    always #2.5 clk = ~clk;

    spy_tap #(.DATA_W(DW), .LEN_W(LW), .DIV_W(VW), .SKIP_W(SW)) i_spy_tap (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_div_m1(cfg_div_m1),
        .cfg_block(cfg_block), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .spy_dat_we(spy_dat_we), .spy_dat(spy_dat), .spy_dat_af(spy_dat_af),
        .spy_len_we(spy_len_we), .spy_len(spy_len), .spy_len_af(spy_len_af),
        .skip_count(skip_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit sel_want(input int mode, input int pc);
        return (mode == 1) || (mode == 2 && pc == 0);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(spy_dat_we === 1'b0, "R1 dat_we", longint'(spy_dat_we), 0);
        chk(spy_len_we === 1'b0, "R1 len_we", longint'(spy_len_we), 0);
        chk(skip_count === '0, "R1 skip", longint'(skip_count), 0);
        rst_n = 1'b1;
        m_in_evt = 0; m_copy = 0; m_pc = 0; m_wcnt = 0; m_skip = 0;
        e_dwe = 0; e_lwe = 0; e_dat = 0; e_len = 0;
        pend = 0; rem = 0;
    endtask

    task automatic one_cycle(input int af_pct, input int af_force);
        bit start, want, room, stl, hs, cp;
        @(negedge clk);
        if (!pend && ($urandom % 4) != 0) begin
            pend = 1;
            if (rem == 0) rem = 1 + ($urandom % 6);
            in_data = $urandom;
            in_last = (rem == 1);
        end
        in_valid   = pend;
        out_ready  = ($urandom % 5) != 0;
        spy_dat_af = (af_force == 1) ? 1'b1 : (($urandom % 100) < af_pct);
        spy_len_af = (af_force == 1) ? 1'b0 : (($urandom % 100) < af_pct);
        #1;
        start = !m_in_evt;
        want  = sel_want(int'(cfg_mode), m_pc);
        room  = !spy_dat_af && !spy_len_af;
        stl   = start && in_valid && want && !room && cfg_block;
        // R2 / R7 handshake behaviour
        chk(in_ready === (out_ready && !stl), cfg_block ? "R7 in_ready" : "R2 in_ready",
            longint'(in_ready), longint'(out_ready && !stl));
        chk(out_valid === (in_valid && !stl), cfg_block ? "R7 out_valid" : "R2 out_valid",
            longint'(out_valid), longint'(in_valid && !stl));
        if (out_valid) begin
            chk(out_data === in_data && out_last === in_last, "R2 out_data",
                longint'(out_data), longint'(in_data));
        end
        // R8 data copy
        chk(spy_dat_we === e_dwe, "R8 dat_we", longint'(spy_dat_we), longint'(e_dwe));
        if (e_dwe) chk(longint'(spy_dat) == e_dat, "R8 dat", longint'(spy_dat), e_dat);
        // R9 length entry
        chk(spy_len_we === e_lwe, "R9 len_we", longint'(spy_len_we), longint'(e_lwe));
        if (e_lwe) chk(longint'(spy_len) == e_len, "R9 len", longint'(spy_len), e_len);
        // R6 / R10 skip counter
        chk(int'(skip_count) == m_skip, "R6 skip", longint'(skip_count), longint'(m_skip));
        // model update for the coming edge
        hs = in_valid && out_ready && !stl;
        cp = start ? (want && room) : m_copy;
        e_dwe = hs && cp;
        e_lwe = hs && cp && in_last;
        e_dat = longint'(in_data);
        e_len = longint'((start ? 0 : m_wcnt) + 1);
        if (hs) begin
            if (start && want && !room && m_skip < SKIP_MAX) m_skip++;
            if (start && cfg_mode == 2'd2) m_pc = (m_pc >= int'(cfg_div_m1)) ? 0 : m_pc + 1;
            m_wcnt   = start ? 1 : m_wcnt + 1;
            m_in_evt = !in_last;
            m_copy   = cp;
            pend     = 0;
            rem--;
        end
    endtask

    task automatic phase(input int mode, input int div, input bit blk,
                         input int af_pct, input int af_force, input int cycles);
        cfg_mode   = 2'(mode);
        cfg_div_m1 = VW'(div);
        cfg_block  = blk;
        do_reset();
        for (int i = 0; i < cycles; i++) one_cycle(af_pct, af_force);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5a17_0c3e));
        phase(1, 0, 0, 20, 0, 2500);       // R3 copy all, R5/R6 random flags
        phase(2, 2, 0, 15, 0, 2500);       // R4 one in three
        phase(2, 0, 0, 10, 0, 1500);       // R4 n = 1
        phase(2, 16'hFFFF, 0, 0, 0, 1500); // R4 n = 65536: only first event
        phase(0, 0, 0, 0, 0, 800);         // R3 off
        phase(3, 0, 0, 0, 0, 800);         // R3 reserved acts as off
        phase(1, 0, 0, 0, 1, 1500);        // R10 flags stuck: skip saturates
        phase(1, 0, 1, 50, 0, 2500);       // R7 blocking copy all
        phase(2, 3, 1, 40, 0, 2500);       // R7 blocking one in four
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule